// File: doc/BRIEF.md
# Three-Shear Lifting Complex Rotator

This block rotates a fixed-point complex sample (x, y) by the twiddle factor W = exp(-j·2πk/N), where k is the twiddle index that comes with the sample. It does not use the four real products of a direct complex multiply. Instead it applies three shears in sequence:

- x1 = x + u·y
- y1 = y + s·x1
- x2 = x1 + u·y1

Here u = (c-1)/s, and the rotated result is (x2, y1). Each shear has its own pipeline register, so the block takes a new sample on every clock. The result appears three clocks after the sample is presented.

A coefficient table inside the block holds, for each index, the lifting coefficient u and the sine s. Both are precomputed, so the data path never derives them. When the angle is larger than a quarter turn, the table entry is built for the residual angle after a half turn. The sample is then negated on entry. This keeps every lifting coefficient within ±1. The two indices whose sine is zero skip the shears. Their samples pass straight through, or are negated.

Every product is rounded on its own before its add. The three steps therefore form an integer-to-integer map that can be inverted exactly by undoing the shears.

Top module: `lift_rotator`

## Requirements
- R1: The block takes one sample per clock. `valid_o` equals `valid_i` delayed by exactly three clock edges, and each result belongs to the sample presented three edges earlier.
- R2: While `rst_ni` is low, and for the first three edges after it rises, `valid_o` is 0.
- R3: Each result matches the following integer model exactly.
  - Flip: the sample is negated when 4k > N and 4k < 3N, giving the residual angle θ = -2πk/N + π; otherwise θ = -2πk/N.
  - Coefficients: U = round((cosθ-1)/sinθ · 2^F) and S = round(sinθ · 2^F), with F = COEF_W-2. Both are 0 when k = 0 or k = N/2.
  - Rounding: each step adds (P + 2^(F-1)) >> F, an arithmetic shift, where P is the full product.
  - Outputs: x_o = x2 and y_o = y1.
- R4: Each output lies within 4 LSB of the real-valued rotation x·cosφ - y·sinφ and x·sinφ + y·cosφ, where φ = -2πk/N. This holds with the default 18-bit coefficients.
- R5: Index 0 returns the input sample unchanged, sign-extended.
- R6: Index N/2 returns the exact negation of both components. This includes the most negative input value.
- R7: Index N/4 returns exactly (y, -x). Index 3N/4 returns exactly (-y, x).
- R8: Samples with different indices presented on consecutive clocks do not disturb each other. Every accepted sample yields exactly one result, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample on x_i/y_i/idx_i is present |
| idx_i | input | $clog2(N_PTS) | Twiddle index k, 0..N_PTS-1 |
| x_i | input | DATA_W | Real part, signed |
| y_i | input | DATA_W | Imaginary part, signed |
| valid_o | output | 1 | Result on x_o/y_o is present |
| x_o | output | DATA_W+2 | Rotated real part, signed |
| y_o | output | DATA_W+2 | Rotated imaginary part, signed |

## Verification
The properties take for granted three things about the inputs:
- N_PTS is a power of two and a multiple of four, so every value of `idx_i` is a legal index.
- `x_i`, `y_i` and `idx_i` are stable around the clock edge at which `valid_i` is high.
- The reset is released at least three edges before any exact-value property is evaluated.

The stimulus drives all inputs half a cycle away from the sampling edge. It uses only indices inside the table and sweeps every one of them. It includes full-scale and most-negative components, so each special index (0, N/4, N/2, 3N/4) is reached with extreme values. Streams run back to back, and idle gaps are inserted so that results are checked both with and without spacing.

// File: rtl/lift_rot_pkg.sv
package lift_rot_pkg;

  localparam real PI = 3.14159265358979323846;

  function automatic int round_real(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  // angle lies beyond a quarter turn: negate sample, rotate by residual
  function automatic bit needs_flip(int k, int n);
    return (4 * k > n) && (4 * k < 3 * n);
  endfunction

  // sine is zero: rotation is +1 or -1
  function automatic bit is_trivial(int k, int n);
    return (k == 0) || (2 * k == n);
  endfunction

  function automatic real residual_angle(int k, int n);
    real th;
    th = -2.0 * PI * real'(k) / real'(n);
    if (needs_flip(k, n)) th = th + PI;
    return th;
  endfunction

  function automatic int lift_coef(int k, int n, int frac);
    real th;
    if (is_trivial(k, n)) return 0;
    th = residual_angle(k, n);
    return round_real(($cos(th) - 1.0) / $sin(th) * (2.0 ** frac));
  endfunction

  function automatic int sine_coef(int k, int n, int frac);
    if (is_trivial(k, n)) return 0;
    return round_real($sin(residual_angle(k, n)) * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/lift_rot_coef_rom.sv
module lift_rot_coef_rom #(
  parameter int N_PTS  = 64,
  parameter int COEF_W = 18,
  parameter int IDX_W  = $clog2(N_PTS)
) (
  input  logic              [IDX_W-1:0]  idx_i,
  output logic signed       [COEF_W-1:0] lift_o,
  output logic signed       [COEF_W-1:0] sine_o,
  output logic                           flip_o,
  output logic                           trivial_o
);
  localparam int FRAC = COEF_W - 2;

  logic signed [COEF_W-1:0] lift_tab [N_PTS];
  logic signed [COEF_W-1:0] sine_tab [N_PTS];
  logic        [N_PTS-1:0]  flip_tab;
  logic        [N_PTS-1:0]  triv_tab;

  for (genvar g = 0; g < N_PTS; g++) begin : g_entry
    localparam int LQ = lift_rot_pkg::lift_coef(g, N_PTS, FRAC);
    localparam int SQ = lift_rot_pkg::sine_coef(g, N_PTS, FRAC);
    assign lift_tab[g] = COEF_W'(LQ);
    assign sine_tab[g] = COEF_W'(SQ);
    assign flip_tab[g] = lift_rot_pkg::needs_flip(g, N_PTS);
    assign triv_tab[g] = lift_rot_pkg::is_trivial(g, N_PTS);
  end

  assign lift_o    = lift_tab[idx_i];
  assign sine_o    = sine_tab[idx_i];
  assign flip_o    = flip_tab[idx_i];
  assign trivial_o = triv_tab[idx_i];
endmodule

// File: rtl/lift_rot_shear.sv
// One lifting step: base + round(coef * lever), coef has CF fraction bits.
module lift_rot_shear #(
  parameter int IW = 18,
  parameter int CW = 18,
  parameter int CF = 16
) (
  input  logic signed [IW-1:0] base_i,
  input  logic signed [IW-1:0] lever_i,
  input  logic signed [CW-1:0] coef_i,
  input  logic                 bypass_i,
  output logic signed [IW-1:0] sum_o
);
  localparam int PW = IW + CW;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CF - 1);

  logic signed [PW-1:0] lever_ext;
  logic signed [PW-1:0] coef_ext;
  logic signed [PW-1:0] prod;

  assign lever_ext = PW'(lever_i);
  assign coef_ext  = PW'(coef_i);
  assign prod      = lever_ext * coef_ext;
  assign sum_o     = bypass_i ? base_i
                              : IW'(PW'(base_i) + ((prod + HALF) >>> CF));
endmodule

// File: rtl/lift_rotator.sv
module lift_rotator #(
  parameter int  DATA_W = 16,
  parameter int  COEF_W = 18,
  parameter int  N_PTS  = 64,
  localparam int IDX_W  = $clog2(N_PTS),
  localparam int OUT_W  = DATA_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic        [IDX_W-1:0]  idx_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  x_o,
  output logic signed [OUT_W-1:0]  y_o
);
  localparam int IW    = OUT_W;
  localparam int FRAC  = COEF_W - 2;
  localparam int DEPTH = 3;

  logic signed [COEF_W-1:0] lift_c, sine_c;
  logic                     flip_c, triv_c;

  lift_rot_coef_rom #(.N_PTS(N_PTS), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_rom (
    .idx_i    (idx_i),
    .lift_o   (lift_c),
    .sine_o   (sine_c),
    .flip_o   (flip_c),
    .trivial_o(triv_c)
  );

  // half-turn pre-rotation keeps |lift| <= 1
  logic signed [IW-1:0] x_ext, y_ext, x_in, y_in;
  assign x_ext = IW'(x_i);
  assign y_ext = IW'(y_i);
  assign x_in  = flip_c ? -x_ext : x_ext;
  assign y_in  = flip_c ? -y_ext : y_ext;

  // step 1
  logic signed [IW-1:0] x1_c;
  lift_rot_shear #(.IW(IW), .CW(COEF_W), .CF(FRAC)) u_sh1 (
    .base_i(x_in), .lever_i(y_in), .coef_i(lift_c), .bypass_i(triv_c), .sum_o(x1_c)
  );

  logic signed [IW-1:0]     s1_x1, s1_y;
  logic signed [COEF_W-1:0] s1_lift, s1_sine;
  logic                     s1_triv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_x1 <= '0; s1_y <= '0; s1_lift <= '0; s1_sine <= '0; s1_triv <= 1'b0;
    end else begin
      s1_x1 <= x1_c; s1_y <= y_in; s1_lift <= lift_c; s1_sine <= sine_c; s1_triv <= triv_c;
    end
  end

  // step 2
  logic signed [IW-1:0] y1_c;
  lift_rot_shear #(.IW(IW), .CW(COEF_W), .CF(FRAC)) u_sh2 (
    .base_i(s1_y), .lever_i(s1_x1), .coef_i(s1_sine), .bypass_i(s1_triv), .sum_o(y1_c)
  );

  logic signed [IW-1:0]     s2_x1, s2_y1;
  logic signed [COEF_W-1:0] s2_lift;
  logic                     s2_triv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_x1 <= '0; s2_y1 <= '0; s2_lift <= '0; s2_triv <= 1'b0;
    end else begin
      s2_x1 <= s1_x1; s2_y1 <= y1_c; s2_lift <= s1_lift; s2_triv <= s1_triv;
    end
  end

  // step 3
  logic signed [IW-1:0] x2_c;
  lift_rot_shear #(.IW(IW), .CW(COEF_W), .CF(FRAC)) u_sh3 (
    .base_i(s2_x1), .lever_i(s2_y1), .coef_i(s2_lift), .bypass_i(s2_triv), .sum_o(x2_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0; y_o <= '0;
    end else begin
      x_o <= x2_c; y_o <= s2_y1;
    end
  end

  logic [DEPTH-1:0] vld_sr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_sr <= '0;
    else         vld_sr <= {vld_sr[DEPTH-2:0], valid_i};
  end
  assign valid_o = vld_sr[DEPTH-1];
endmodule

// File: rtl/lift_rotator_chk.sv
module lift_rotator_chk #(
  parameter int  DATA_W = 16,
  parameter int  COEF_W = 18,
  parameter int  N_PTS  = 64,
  localparam int IDX_W  = $clog2(N_PTS),
  localparam int OUT_W  = DATA_W + 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic        [IDX_W-1:0]  idx_i,
  input logic signed [DATA_W-1:0] x_i,
  input logic signed [DATA_W-1:0] y_i,
  input logic                     valid_o,
  input logic signed [OUT_W-1:0]  x_o,
  input logic signed [OUT_W-1:0]  y_o
);
  localparam logic [IDX_W-1:0] K_ZERO = '0;
  localparam logic [IDX_W-1:0] K_Q1   = IDX_W'(N_PTS / 4);
  localparam logic [IDX_W-1:0] K_HALF = IDX_W'(N_PTS / 2);
  localparam logic [IDX_W-1:0] K_Q3   = IDX_W'(3 * N_PTS / 4);

  // edges since reset, saturating at the pipeline depth
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  assert_quiet_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd3) |-> !valid_o);

  assert_identity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(valid_i, 3) && $past(idx_i, 3) == K_ZERO) |->
    (x_o == OUT_W'($past(x_i, 3)) && y_o == OUT_W'($past(y_i, 3))));

  assert_negate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(valid_i, 3) && $past(idx_i, 3) == K_HALF) |->
    (x_o == -OUT_W'($past(x_i, 3)) && y_o == -OUT_W'($past(y_i, 3))));

  assert_quarter_cw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(valid_i, 3) && $past(idx_i, 3) == K_Q1) |->
    (x_o == OUT_W'($past(y_i, 3)) && y_o == -OUT_W'($past(x_i, 3))));

  assert_quarter_ccw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(valid_i, 3) && $past(idx_i, 3) == K_Q3) |->
    (x_o == -OUT_W'($past(y_i, 3)) && y_o == OUT_W'($past(x_i, 3))));
endmodule

bind lift_rotator lift_rotator_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .N_PTS(N_PTS)
) u_chk (.*);

// File: tb/lift_rotator_test.sv
module lift_rotator_test;
  localparam int  DATA_W = 16;
  localparam int  COEF_W = 18;
  localparam int  N_PTS  = 64;
  localparam int  IDX_W  = 6;
  localparam int  OUT_W  = DATA_W + 2;
  localparam int  FRAC   = COEF_W - 2;
  localparam real PI     = 3.14159265358979323846;

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     valid_i = 1'b0;
  logic        [IDX_W-1:0]  idx_i = '0;
  logic signed [DATA_W-1:0] x_i = '0;
  logic signed [DATA_W-1:0] y_i = '0;
  logic                     valid_o;
  logic signed [OUT_W-1:0]  x_o, y_o;

  always #2 clk = ~clk;

  lift_rotator #(.DATA_W(DATA_W), .COEF_W(COEF_W), .N_PTS(N_PTS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .idx_i(idx_i),
    .x_i(x_i), .y_i(y_i), .valid_o(valid_o), .x_o(x_o), .y_o(y_o)
  );

  typedef struct {
    int     idx;
    longint xin, yin, xe, ye, stamp;
    real    xr, yr;
  } exp_t;

  exp_t   sbq[$];
  int     n_chk = 0, n_err = 0, n_in = 0, n_out = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint rnd(real v);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(-v + 0.5));
  endfunction

  function automatic longint shr(longint p);
    return (p + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
  endfunction

  // R3 integer lifting model and R4 real reference
  function automatic exp_t predict(int k, int x, int y);
    exp_t   e;
    bit     flip, triv;
    real    th, phi;
    longint uq, sq, xa, ya, x1, y1;
    flip = (4 * k > N_PTS) && (4 * k < 3 * N_PTS);
    triv = (k == 0) || (2 * k == N_PTS);
    th = -2.0 * PI * real'(k) / real'(N_PTS) + (flip ? PI : 0.0);
    uq = triv ? 0 : rnd(($cos(th) - 1.0) / $sin(th) * (2.0 ** FRAC));
    sq = triv ? 0 : rnd($sin(th) * (2.0 ** FRAC));
    xa = flip ? -longint'(x) : longint'(x);
    ya = flip ? -longint'(y) : longint'(y);
    if (triv) begin
      e.xe = xa; e.ye = ya;
    end else begin
      x1 = xa + shr(uq * ya);
      y1 = ya + shr(sq * x1);
      e.xe = x1 + shr(uq * y1);
      e.ye = y1;
    end
    phi  = -2.0 * PI * real'(k) / real'(N_PTS);
    e.xr = real'(x) * $cos(phi) - real'(y) * $sin(phi);
    e.yr = real'(x) * $sin(phi) + real'(y) * $cos(phi);
    e.idx = k; e.xin = x; e.yin = y; e.stamp = 0;
    return e;
  endfunction

  task automatic send(int k, int x, int y);
    exp_t e;
    valid_i = 1'b1;
    idx_i   = IDX_W'(k);
    x_i     = DATA_W'(x);
    y_i     = DATA_W'(y);
    e = predict(k, x, y);
    e.stamp = cyc;
    sbq.push_back(e);
    n_in++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    valid_i = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      exp_t   e;
      longint ax, ay;
      real    dx, dy;
      n_out++;
      if (sbq.size() == 0) begin
        chk(1'b0, "R8 unexpected result", 1, 0);
      end else begin
        e  = sbq.pop_front();
        ax = longint'(x_o);
        ay = longint'(y_o);
        chk(cyc - e.stamp == 3, "R1 latency", cyc - e.stamp, 3);
        chk(ax == e.xe, "R3 x bit-exact", ax, e.xe);
        chk(ay == e.ye, "R3 y bit-exact", ay, e.ye);
        dx = real'(ax) - e.xr; dy = real'(ay) - e.yr;
        chk(dx <= 4.0 && dx >= -4.0, "R4 x tolerance", ax, rnd(e.xr));
        chk(dy <= 4.0 && dy >= -4.0, "R4 y tolerance", ay, rnd(e.yr));
        if (e.idx == 0) begin
          chk(ax == e.xin && ay == e.yin, "R5 identity", ax, e.xin);
        end else if (e.idx == N_PTS / 2) begin
          chk(ax == -e.xin && ay == -e.yin, "R6 negate", ax, -e.xin);
        end else if (e.idx == N_PTS / 4) begin
          chk(ax == e.yin && ay == -e.xin, "R7 quarter (y,-x)", ax, e.yin);
        end else if (e.idx == 3 * N_PTS / 4) begin
          chk(ax == -e.yin && ay == e.xin, "R7 quarter (-y,x)", ax, -e.yin);
        end
      end
    end
  end

  function automatic int pat_x(int p, int k);
    case (p)
      0: return 32767;
      1: return 0;
      2: return -32768;
      3: return 32767;
      default: return ((k * 7919 + p * 131) % 65536) - 32768;
    endcase
  endfunction

  function automatic int pat_y(int p, int k);
    case (p)
      0: return 0;
      1: return -32768;
      2: return -32768;
      3: return 32767;
      default: return ((k * 104729 + 12345 + p * 977) % 65536) - 32768;
    endcase
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R2: quiet during and right after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R2 valid in reset", valid_o, 0);
      chk(x_o == '0 && y_o == '0, "R2 data in reset", x_o, 0);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R2 valid after reset", valid_o, 0);
    end
    // R8: back-to-back sweep of every index, several patterns
    for (int p = 0; p < 7; p++) begin
      for (int k = 0; k < N_PTS; k++) begin
        send(k, pat_x(p, k), pat_y(p, k));
        if (p == 5 && (k % 7) == 3) idle(k % 3 + 1);
      end
    end
    // R8: alternating extremes across special indices
    for (int k = 0; k < 4; k++) begin
      send(k * N_PTS / 4, -32768, 32767);
      send(k * N_PTS / 4 + 1, 32767, -32768);
    end
    idle(8);
    chk(sbq.size() == 0, "R8 pending results", sbq.size(), 0);
    chk(n_out == n_in, "R8 result count", n_out, n_in);
    summary();
    $finish;
  end
endmodule